// File: doc/BRIEF.md
# Wavefront Result Collector with Forwarding

The collector sits between a 16-lane arithmetic pipeline and a register file that holds rows of 64 work-item values. A single instruction produces up to 64 results, and they arrive over several cycles. When some work-items are predicated off, the surviving results come in compacted and out of slot order. Every lane result carries the index of the work-item it belongs to. The collector uses that index to scatter the result into the matching slot of a row buffer. It follows an execution mask to know which slots still owe a result. Once the last expected slot is filled, it issues one register-file write. That write covers the whole row, goes to one destination address, and carries a per-item enable.

The enable on the write is the AND of two masks: the execution mask, and a separate write mask that blocks updates to chosen items. The assembled row stays available on a forwarding port. The instruction that follows can compare one of its source addresses against the destination and take the new values directly, without waiting for the write and a re-read. A new instruction is announced with a start pulse that carries both masks and the destination. While a row is still being collected, a start pulse is not accepted.

Top module: `wave_result_collector`

## Requirements
- R1: After reset, `rf_we_o` and `fwd_hit_o` are 0, and `rf_mask_o` and `fwd_mask_o` are all zero.
- R2: A start pulse is taken only when no row is being collected, i.e. when idle or in the write cycle. The collector then latches the execution mask, the write mask and the destination address. A start pulse that arrives while a row is being collected has no effect on the pending write's address or mask.
- R3: A valid lane result with index i is stored in slot i of the row, whichever lane carried it, when all of these hold: execution-mask bit i is 1, slot i has not yet been filled for this instruction, and a row is being collected.
- R4: The collector discards a result and never writes or counts it in either case: its slot's execution-mask bit is 0, or it arrives while no row is being collected (including the cycle in which the start pulse is sampled).
- R5: Once a slot is filled, later results for it in the same instruction are discarded. When several lanes name the same slot in the same cycle, the lowest-numbered lane wins.
- R6: `rf_we_o` is high for exactly one cycle. That cycle follows the clock edge at which the last slot set in the execution mask was filled. With an all-zero execution mask, `rf_we_o` is high in the second cycle after the start pulse is sampled.
- R7: In the write cycle, `rf_addr_o` is the latched destination and `rf_mask_o` is the execution mask AND the write mask. Every enabled slot of `rf_data_o` holds the result received for that slot. Outside the write cycle, `rf_mask_o` is zero.
- R8: With an all-ones execution mask, lane l delivers slot 16c+l in cycle c, and the row is written after the fourth delivery cycle with every slot in its own position.
- R9: `fwd_hit_o` is 1 when both of these hold: the row has completed (from its write cycle until the next accepted start), and `fwd_src_i` equals the latched destination. On a hit, `fwd_mask_o` is the execution mask AND the write mask, and `fwd_data_o` carries the new values in the enabled slots. Otherwise `fwd_mask_o` is zero.
- R10: While a row is being collected, `fwd_hit_o` is 0 even when `fwd_src_i` equals the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Announces a new instruction |
| start_exec_i | input | ITEMS | Execution mask: slots that will receive a result |
| start_wmask_i | input | ITEMS | Write mask: slots allowed to update |
| start_dst_i | input | AW | Destination register address |
| res_valid_i | input | LANES | Per-lane result valid |
| res_idx_i | input | LANES x IW | Per-lane work-item index |
| res_data_i | input | LANES x DW | Per-lane result value |
| rf_we_o | output | 1 | Full-row write strobe |
| rf_addr_o | output | AW | Write address |
| rf_mask_o | output | ITEMS | Per-item write enable |
| rf_data_o | output | ITEMS x DW | Row written to the register file |
| fwd_src_i | input | AW | Source address of the following instruction |
| fwd_hit_o | output | 1 | Forwarded row matches the source |
| fwd_mask_o | output | ITEMS | Slots that carry new data on a hit |
| fwd_data_o | output | ITEMS x DW | Forwarded row |

## Verification
Some invariants are checked by the assertions on every cycle. The fill bitmap never holds a slot outside the execution mask. No filled slot is written a second time, and no more than one result per lane is accepted in a cycle. A write happens only with every expected slot filled, and it lasts one cycle. The destination holds steady across an ignored start, and the forward port is never live during collection. The bench's scenarios cover what the assertions cannot. Those are the actual scatter of compacted, reversed and duplicated results into the right slots, the lowest-lane tie-break, and the exact cycle of the write, including the all-zero mask case. They also cover the back-to-back hand-off in which a new start in the write cycle ends forwarding of the old row.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int unsigned RC_LANES = 16;
    localparam int unsigned RC_ITEMS = 64;
    localparam int unsigned RC_DW    = 32;
    localparam int unsigned RC_AW    = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2
    } rc_state_e;

    function automatic int unsigned rc_idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rc_scatter.sv
module rc_scatter #(
    parameter int LANES = 16,
    parameter int ITEMS = 64,
    parameter int DW    = 32,
    parameter int IW    = 6
) (
    input  logic                        collecting_i,
    input  logic [ITEMS-1:0]            exec_i,
    input  logic [ITEMS-1:0]            filled_i,
    input  logic [LANES-1:0]            res_valid_i,
    input  logic [LANES-1:0][IW-1:0]    res_idx_i,
    input  logic [LANES-1:0][DW-1:0]    res_data_i,
    output logic [ITEMS-1:0]            slot_we_o,
    output logic [ITEMS-1:0][DW-1:0]    slot_data_o
);

    // Each slot picks the lowest-numbered lane that names it.
    for (genvar s = 0; s < ITEMS; s++) begin : g_slot
        logic          hit;
        logic [DW-1:0] pick;

        always_comb begin
            hit  = 1'b0;
            pick = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (res_valid_i[l] && (res_idx_i[l] == IW'(s))) begin
                    hit  = 1'b1;
                    pick = res_data_i[l];
                end
            end
        end

        assign slot_we_o[s]   = hit & collecting_i & exec_i[s] & ~filled_i[s];
        assign slot_data_o[s] = pick;
    end

endmodule

// File: rtl/rc_row_buf.sv
module rc_row_buf #(
    parameter int LANES = 16,
    parameter int ITEMS = 64,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear_i,
    input  logic [ITEMS-1:0]         exec_i,
    input  logic [ITEMS-1:0]         slot_we_i,
    input  logic [ITEMS-1:0][DW-1:0] slot_data_i,
    output logic [ITEMS-1:0]         filled_o,
    output logic [ITEMS-1:0][DW-1:0] row_o
);

    logic [ITEMS-1:0]         filled_q;
    logic [ITEMS-1:0][DW-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            filled_q <= '0;
        end else if (clear_i) begin
            filled_q <= '0;
        end else begin
            filled_q <= filled_q | slot_we_i;
        end
    end

    // Data storage carries no reset; only enabled slots are ever consumed.
    always_ff @(posedge clk) begin
        for (int s = 0; s < ITEMS; s++) begin
            if (slot_we_i[s]) begin
                row_q[s] <= slot_data_i[s];
            end
        end
    end

    assign filled_o = filled_q;
    assign row_o    = row_q;

    // R4
    filled_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (filled_q & ~exec_i) == '0);

    // R5
    no_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_we_i & filled_q) == '0);

    // R5
    accept_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_we_i) <= LANES);

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import rc_pkg::*;
#(
    parameter int ITEMS = 64,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [ITEMS-1:0] start_exec_i,
    input  logic [ITEMS-1:0] start_wmask_i,
    input  logic [AW-1:0]    start_dst_i,
    input  logic [ITEMS-1:0] filled_i,
    input  logic [ITEMS-1:0] slot_we_i,
    output logic             collecting_o,
    output logic             commit_o,
    output logic             clear_o,
    output logic             row_valid_o,
    output logic [ITEMS-1:0] exec_o,
    output logic [ITEMS-1:0] eff_mask_o,
    output logic [AW-1:0]    dst_o
);

    typedef struct packed {
        logic [ITEMS-1:0] exec;
        logic [ITEMS-1:0] wmask;
        logic [AW-1:0]    dst;
    } rc_cmd_t;

    rc_state_e state_q, state_d;
    rc_cmd_t   cmd_q;
    logic      row_valid_q;
    logic      accept;
    logic      done;

    assign accept = start_i && (state_q != ST_COLLECT);
    assign done   = (state_q == ST_COLLECT) && ((filled_i | slot_we_i) == cmd_q.exec);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_COLLECT;
            ST_COLLECT: if (done)   state_d = ST_COMMIT;
            ST_COMMIT:  state_d = accept ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cmd_q       <= '0;
            row_valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_q.exec  <= start_exec_i;
                cmd_q.wmask <= start_wmask_i;
                cmd_q.dst   <= start_dst_i;
                row_valid_q <= 1'b0;
            end else if (done) begin
                row_valid_q <= 1'b1;
            end
        end
    end

    assign collecting_o = (state_q == ST_COLLECT);
    assign commit_o     = (state_q == ST_COMMIT);
    assign clear_o      = accept;
    assign row_valid_o  = row_valid_q;
    assign exec_o       = cmd_q.exec;
    assign eff_mask_o   = cmd_q.exec & cmd_q.wmask;
    assign dst_o        = cmd_q.dst;

    // R6
    commit_full_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |-> (filled_i == cmd_q.exec));

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |=> (state_q != ST_COMMIT));

    // R2
    dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COLLECT) |=> (state_q != ST_COLLECT) || $stable(cmd_q));

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(row_valid_q) |-> (state_q == ST_COMMIT));

endmodule

// File: rtl/rc_fwd.sv
module rc_fwd #(
    parameter int ITEMS = 64,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic                     row_valid_i,
    input  logic [AW-1:0]            dst_i,
    input  logic [AW-1:0]            src_i,
    input  logic [ITEMS-1:0]         eff_mask_i,
    input  logic [ITEMS-1:0][DW-1:0] row_i,
    output logic                     hit_o,
    output logic [ITEMS-1:0]         mask_o,
    output logic [ITEMS-1:0][DW-1:0] data_o
);

    assign hit_o  = row_valid_i && (src_i == dst_i);
    assign mask_o = hit_o ? eff_mask_i : '0;
    assign data_o = row_i;

endmodule

// File: rtl/wave_result_collector.sv
module wave_result_collector
    import rc_pkg::*;
#(
    parameter int LANES = RC_LANES,
    parameter int ITEMS = RC_ITEMS,
    parameter int DW    = RC_DW,
    parameter int AW    = RC_AW,
    localparam int IW   = rc_idx_bits(ITEMS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [ITEMS-1:0]         start_exec_i,
    input  logic [ITEMS-1:0]         start_wmask_i,
    input  logic [AW-1:0]            start_dst_i,
    input  logic [LANES-1:0]         res_valid_i,
    input  logic [LANES-1:0][IW-1:0] res_idx_i,
    input  logic [LANES-1:0][DW-1:0] res_data_i,
    output logic                     rf_we_o,
    output logic [AW-1:0]            rf_addr_o,
    output logic [ITEMS-1:0]         rf_mask_o,
    output logic [ITEMS-1:0][DW-1:0] rf_data_o,
    input  logic [AW-1:0]            fwd_src_i,
    output logic                     fwd_hit_o,
    output logic [ITEMS-1:0]         fwd_mask_o,
    output logic [ITEMS-1:0][DW-1:0] fwd_data_o
);

    logic                     collecting;
    logic                     commit;
    logic                     clear;
    logic                     row_valid;
    logic [ITEMS-1:0]         exec_q;
    logic [ITEMS-1:0]         eff_mask;
    logic [AW-1:0]            dst_q;
    logic [ITEMS-1:0]         filled;
    logic [ITEMS-1:0]         slot_we;
    logic [ITEMS-1:0][DW-1:0] slot_data;
    logic [ITEMS-1:0][DW-1:0] row;

    rc_ctrl #(.ITEMS(ITEMS), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_exec_i (start_exec_i),
        .start_wmask_i(start_wmask_i),
        .start_dst_i  (start_dst_i),
        .filled_i     (filled),
        .slot_we_i    (slot_we),
        .collecting_o (collecting),
        .commit_o     (commit),
        .clear_o      (clear),
        .row_valid_o  (row_valid),
        .exec_o       (exec_q),
        .eff_mask_o   (eff_mask),
        .dst_o        (dst_q)
    );

    rc_scatter #(.LANES(LANES), .ITEMS(ITEMS), .DW(DW), .IW(IW)) u_scatter (
        .collecting_i(collecting),
        .exec_i      (exec_q),
        .filled_i    (filled),
        .res_valid_i (res_valid_i),
        .res_idx_i   (res_idx_i),
        .res_data_i  (res_data_i),
        .slot_we_o   (slot_we),
        .slot_data_o (slot_data)
    );

    rc_row_buf #(.LANES(LANES), .ITEMS(ITEMS), .DW(DW)) u_row (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .exec_i     (exec_q),
        .slot_we_i  (slot_we),
        .slot_data_i(slot_data),
        .filled_o   (filled),
        .row_o      (row)
    );

    rc_fwd #(.ITEMS(ITEMS), .DW(DW), .AW(AW)) u_fwd (
        .row_valid_i(row_valid),
        .dst_i      (dst_q),
        .src_i      (fwd_src_i),
        .eff_mask_i (eff_mask),
        .row_i      (row),
        .hit_o      (fwd_hit_o),
        .mask_o     (fwd_mask_o),
        .data_o     (fwd_data_o)
    );

    assign rf_we_o   = commit;
    assign rf_addr_o = dst_q;
    assign rf_mask_o = commit ? eff_mask : '0;
    assign rf_data_o = row;

    // R10
    fwd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        collecting |-> !fwd_hit_o);

    // R7
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rf_we_o |-> (rf_mask_o == '0));

endmodule

// File: tb/wave_result_collector_tb.sv
`timescale 1ns/1ps
module wave_result_collector_tb;

    localparam int L  = 16;
    localparam int N  = 64;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int IW = 6;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic [N-1:0]          s_exec = '0;
    logic [N-1:0]          s_wm = '0;
    logic [AW-1:0]         s_dst = '0;
    logic [L-1:0]          lv = '0;
    logic [L-1:0][IW-1:0]  li = '0;
    logic [L-1:0][DW-1:0]  ld = '0;
    logic [AW-1:0]         src = '0;
    logic                  rf_we;
    logic [AW-1:0]         rf_addr;
    logic [N-1:0]          rf_mask;
    logic [N-1:0][DW-1:0]  rf_data;
    logic                  fwd_hit;
    logic [N-1:0]          fwd_mask;
    logic [N-1:0][DW-1:0]  fwd_data;

    always #4 clk = ~clk;

    wave_result_collector u_dut (
        .clk(clk), .rst(rst), .start_i(start), .start_exec_i(s_exec),
        .start_wmask_i(s_wm), .start_dst_i(s_dst), .res_valid_i(lv),
        .res_idx_i(li), .res_data_i(ld), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
        .rf_mask_o(rf_mask), .rf_data_o(rf_data), .fwd_src_i(src),
        .fwd_hit_o(fwd_hit), .fwd_mask_o(fwd_mask), .fwd_data_o(fwd_data)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;
    string scen = "reset";

    // Behavioural reference
    int           m_phase = 0;  // 0 idle, 1 collecting, 2 writing
    logic [N-1:0] m_exec = '0, m_wm = '0, m_filled = '0;
    logic [AW-1:0] m_dst = '0;
    bit           m_rv = 0;
    logic [DW-1:0] m_row [N];

    task automatic chk(input string tag, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: got %h exp %h", tag, scen, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0; m_rv = 0; m_filled = '0; m_exec = '0; m_wm = '0; m_dst = '0;
        end else if (m_phase == 1) begin
            for (int l = 0; l < L; l++) begin
                int ix;
                ix = int'(li[l]);
                if (lv[l] && m_exec[ix] && !m_filled[ix]) begin
                    m_filled[ix] = 1'b1;
                    m_row[ix] = ld[l];
                end
            end
            if (m_filled == m_exec) begin
                m_phase = 2; m_rv = 1;
            end
        end else begin
            if (start) begin
                m_phase = 1; m_exec = s_exec; m_wm = s_wm; m_dst = s_dst;
                m_filled = '0; m_rv = 0;
            end else begin
                m_phase = 0;
            end
        end
        cmp_on = 1;
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [N-1:0] em;
            bit eh;
            em = m_wm & m_exec;
            eh = m_rv && (src == m_dst);
            chk("R6", "rf_we", 64'(rf_we), 64'(m_phase == 2));
            chk("R7", "rf_mask", rf_mask, (m_phase == 2) ? em : '0);
            if (m_phase == 2) begin
                chk("R7", "rf_addr", 64'(rf_addr), 64'(m_dst));
                for (int s = 0; s < N; s++)
                    if (em[s]) chk("R7", $sformatf("rf_data[%0d]", s), 64'(rf_data[s]), 64'(m_row[s]));
            end
            chk((m_phase == 1) ? "R10" : "R9", "fwd_hit", 64'(fwd_hit), 64'(eh));
            chk("R9", "fwd_mask", fwd_mask, eh ? em : '0);
            if (eh)
                for (int s = 0; s < N; s++)
                    if (em[s]) chk("R9", $sformatf("fwd_data[%0d]", s), 64'(fwd_data[s]), 64'(m_row[s]));
        end
    end

    always @(posedge clk) begin
        if (cyc >= 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [DW-1:0] mkval(input int tag, input int idx);
        return DW'((tag << 16) | (idx * 37 + 5));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_lanes();
        lv = '0; li = '0; ld = '0;
    endtask

    task automatic begin_instr(input logic [N-1:0] ex, input logic [N-1:0] wm,
                               input logic [AW-1:0] dst);
        start = 1'b1; s_exec = ex; s_wm = wm; s_dst = dst;
        tick();
        start = 1'b0;
    endtask

    task automatic put(input int lane, input int idx, input logic [DW-1:0] v);
        lv[lane] = 1'b1; li[lane] = IW'(idx); ld[lane] = v;
    endtask

    initial begin
        int act[$];
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rf_we", 64'(rf_we), 64'd0);
        chk("R1", "fwd_hit", 64'(fwd_hit), 64'd0);
        chk("R1", "rf_mask", rf_mask, 64'd0);
        chk("R1", "fwd_mask", fwd_mask, 64'd0);
        tick();

        // R8: full mask, natural order over four cycles
        scen = "R8 full mask";
        src = 8'h10;
        begin_instr('1, '1, 8'h10);
        for (int c = 0; c < 4; c++) begin
            for (int l = 0; l < L; l++) put(l, c * 16 + l, mkval(1, c * 16 + l));
            tick();
        end
        idle_lanes();
        repeat (3) tick();

        // R3: compacted, reversed delivery with partial write mask
        scen = "R3 scatter";
        src = 8'h21;
        begin_instr(64'hF0F0_0F0F_3C3C_A5A5, 64'hFFFF_0000_FFFF_00FF, 8'h21);
        act.delete();
        for (int s = 0; s < N; s++) if (s_exec[s]) act.push_back(s);
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < L; l++) begin
                int ix;
                ix = act[31 - (c * 16 + l)];
                put(l, ix, mkval(2, ix));
            end
            tick();
        end
        idle_lanes();
        repeat (2) tick();
        src = 8'h22;
        tick();

        // R4: stray results while idle, in the start cycle, and outside the mask
        scen = "R4 discard";
        src = 8'h30;
        for (int l = 0; l < 8; l++) put(l, l, mkval(9, l));
        tick();
        for (int l = 0; l < 8; l++) put(l, l, mkval(8, l));
        begin_instr(64'h0000_0000_0000_00FF, '1, 8'h30);
        idle_lanes();
        for (int l = 0; l < 8; l++) put(l, l + 8, mkval(7, l + 8));
        for (int l = 0; l < 4; l++) put(l + 8, l, mkval(3, l));
        tick();
        idle_lanes();
        for (int l = 0; l < 4; l++) put(l, l + 4, mkval(3, l + 4));
        tick();
        idle_lanes();
        repeat (2) tick();

        // R5: duplicates, same cycle and later
        scen = "R5 duplicates";
        src = 8'h40;
        begin_instr(64'h0F, '1, 8'h40);
        put(5, 2, 32'hBBBB_0002);
        put(0, 2, 32'hAAAA_0002);
        put(3, 0, 32'hAAAA_0000);
        tick();
        idle_lanes();
        put(1, 0, 32'hCCCC_0000);
        put(2, 1, 32'hAAAA_0001);
        tick();
        idle_lanes();
        put(4, 3, 32'hAAAA_0003);
        put(6, 2, 32'hDDDD_0002);
        tick();
        idle_lanes();
        repeat (2) tick();

        // R2: start during collection is ignored
        scen = "R2 busy start";
        src = 8'h11;
        begin_instr(64'h3, 64'h1, 8'h11);
        begin_instr('1, '1, 8'h22);
        put(7, 1, mkval(4, 1));
        tick();
        idle_lanes();
        begin_instr('1, '1, 8'h23);
        put(2, 0, mkval(4, 0));
        tick();
        idle_lanes();
        repeat (2) tick();

        // R6: empty execution mask commits with no enables
        scen = "R6 empty mask";
        src = 8'h33;
        begin_instr('0, '1, 8'h33);
        repeat (3) tick();

        // R9 / R10: back-to-back hand-off, start in the write cycle
        scen = "R9 back-to-back";
        src = 8'h50;
        begin_instr(64'hFFFF_0000_0000_0000, '1, 8'h50);
        for (int l = 0; l < L; l++) put(l, 48 + ((l * 5) % 16), mkval(5, 48 + ((l * 5) % 16)));
        tick();
        idle_lanes();
        begin_instr(64'h1, '1, 8'h51);
        src = 8'h51;
        repeat (2) tick();
        src = 8'h50;
        tick();
        src = 8'h51;
        put(9, 0, mkval(6, 0));
        tick();
        idle_lanes();
        src = 8'h52;
        tick();
        src = 8'h51;
        repeat (2) tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule